// File: doc/BRIEF.md
# Completed-Period Index Queue

This block sits between a hardware producer that fills a ring buffer one period at a time and a consumer that drains those periods. Each time the producer finishes a period it pulses `push_valid` with the number of that period (numbers count 0 up to the period count minus one, then start again at 0). The block queues these numbers in arrival order and keeps a separate count of periods that are ready to be read.

The consumer asks for work with a valid/ready request. An accepted request is answered with the oldest queued period number. If nothing is queued, the request waits up to `tmo_cycles` clock edges for a completion and then gives up with a no-data status; a setting of zero turns the request into a non-blocking poll. When the queue is already full, a new completion pushes out the oldest number instead of being refused, the ready count stays where it is, and a saturating drop counter records the loss.

Back-pressure rules: the push side has no ready signal and every push is taken. The request side is stalled by `req_ready`, which is low while a request is outstanding. The response is a single-cycle pulse on `rsp_valid` with no back-pressure; the consumer must capture it in that cycle.

Top module: `period_index_queue`

## Requirements
- R1: After reset `avail_count` and `drop_count` are 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A push while the queue is not full stores `push_idx` behind the newest entry and raises `avail_count` by one on that clock edge; pushes are never refused.
- R3: A push while the queue holds DEPTH entries and no pop takes place on the same edge removes the oldest entry, stores the new index, leaves `avail_count` at DEPTH and adds one to `drop_count` (saturating at its maximum).
- R4: Successful responses carry status code 0 (ok) and return indices in the order they were pushed.
- R5: A request is accepted on an edge where `req_valid` and `req_ready` are both 1; if an index is queued at that edge, the response is produced on that same edge (`rsp_valid` high in the following cycle) and `avail_count` falls by one.
- R6: While an accepted request is waiting, `req_ready` is 0, and the request is served on the first edge at which an index is queued.
- R7: With `tmo_cycles` = T > 0 and nothing arriving, a response with status code 1 (no data) is produced on the T-th edge after the accepting edge; with T = 0 it is produced on the accepting edge itself.
- R8: A push and a pop on the same edge are both carried out: the pop returns the entry that was oldest before the edge, the pushed index joins the queue, and when the queue was full nothing is dropped and `avail_count` is unchanged.
- R9: Status code 2 (bad state) is reserved for a ready count that is nonzero while the queue is empty; the count and the queue are kept by separate logic and agree at all times, so code 2 never appears in operation.
- R10: `rsp_valid` is a pulse of one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Period-completion pulse |
| push_idx | input | IDX_W | Number of the period just completed |
| req_valid | input | 1 | Consumer request |
| req_ready | output | 1 | Request can be accepted |
| tmo_cycles | input | TMO_W | Wait limit in clock edges; 0 means poll |
| rsp_valid | output | 1 | Response pulse |
| rsp_idx | output | IDX_W | Returned period number (valid with status 0) |
| rsp_status | output | 2 | 0 ok, 1 no data, 2 bad state |
| avail_count | output | CNT_W | Periods ready to be read |
| drop_count | output | DROP_W | Indices discarded on full pushes |

## Verification
The bench builds the block with DEPTH = 4, NUM_PERIODS = 6 and an 8-bit timeout, so a handful of pushes walks the index wrap from 5 back to 0 and overruns the queue several times over. Every fill level from one to DEPTH is drained and compared against an arithmetic model, every timeout from 0 to 6 is swept and its response latency counted, and simultaneous push and pop is driven at partial and full occupancy, where the full case is the one that separates a replacement from an ordinary append.

// File: rtl/pidxq_pkg.sv
package pidxq_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_NODATA   = 2'd1,
    ST_BADSTATE = 2'd2
  } rsp_status_e;
endpackage

// File: rtl/pidxq_ring.sv
// Circular store of period indices with replace-oldest on a full push.
module pidxq_ring #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             drop_evt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (occ == CNT_W'(DEPTH));
  assign drop_evt = push & full & ~pop;
  assign head_idx = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop || drop_evt) rd_ptr <= step(rd_ptr);
      if (push && !pop && !full) occ <= occ + CNT_W'(1);
      else if (pop && !push)     occ <= occ - CNT_W'(1);
    end
  end

  // R9: a pop is only issued against a nonempty store
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (occ != '0));
  // R3: occupancy never exceeds the depth
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));
  // R3: a replacing push keeps the store full
  p_full_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> full);
endmodule

// File: rtl/pidxq_avail.sv
// Ready-period count and saturating drop counter, kept apart from the store.
module pidxq_avail #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              at_cap,
  output logic [CNT_W-1:0]  avail,
  output logic [DROP_W-1:0] drops
);
  logic replace;
  assign replace = push & at_cap & ~pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail <= '0;
      drops <= '0;
    end else begin
      if (push && !pop && !at_cap) avail <= avail + CNT_W'(1);
      else if (pop && !push)       avail <= avail - CNT_W'(1);
      if (replace && (drops != '1)) drops <= drops + DROP_W'(1);
    end
  end

  // R3: a replacing push leaves the count where it was
  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    replace |=> (avail == $past(avail)));
  // R3: each replacement is recorded until saturation
  p_drop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (replace && (drops != '1)) |=> (drops == $past(drops) + DROP_W'(1)));
  // R2: an ordinary push raises the count
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !at_cap) |=> (avail == $past(avail) + CNT_W'(1)));
endmodule

// File: rtl/pidxq_ctrl.sv
// Request acceptance, wait timer and response register.
module pidxq_ctrl
  import pidxq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [TMO_W-1:0] tmo_cfg,
  input  logic             avail_nz,
  input  logic             occ_nz,
  input  logic [IDX_W-1:0] head_idx,
  output logic             req_ready,
  output logic             pop,
  output logic             rsp_valid,
  output logic [IDX_W-1:0] rsp_idx,
  output rsp_status_e      rsp_status
);
  logic             pending;
  logic [TMO_W-1:0] wait_cnt, tmo_q;
  logic             accept, active, bad, give_up, finish;

  assign req_ready = ~pending;
  assign accept    = req_valid & ~pending;
  assign active    = accept | pending;
  assign pop       = active & avail_nz & occ_nz;
  assign bad       = active & avail_nz & ~occ_nz;
  assign give_up   = ~avail_nz & ((accept & (tmo_cfg == '0)) |
                                  (pending & (wait_cnt >= tmo_q)));
  assign finish    = pop | bad | give_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      wait_cnt   <= '0;
      tmo_q      <= '0;
      rsp_valid  <= 1'b0;
      rsp_idx    <= '0;
      rsp_status <= ST_OK;
    end else begin
      rsp_valid <= finish;
      if (pop)          rsp_status <= ST_OK;
      else if (bad)     rsp_status <= ST_BADSTATE;
      else if (give_up) rsp_status <= ST_NODATA;
      if (pop) rsp_idx <= head_idx;
      if (finish)      pending <= 1'b0;
      else if (accept) pending <= 1'b1;
      if (accept) begin
        wait_cnt <= TMO_W'(1);
        tmo_q    <= tmo_cfg;
      end else if (pending) begin
        wait_cnt <= wait_cnt + TMO_W'(1);
      end
    end
  end

  // R7: a no-data answer follows an edge with nothing ready
  p_nodata_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_NODATA) |-> !$past(avail_nz));
  // R7: the wait counter never passes the latched limit
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (wait_cnt <= tmo_q));
  // R6: a waiting request is served as soon as data appears
  p_serve_prompt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && avail_nz && occ_nz) |=> (rsp_valid && rsp_status == ST_OK));
  // R10: a response ends the outstanding request
  p_rsp_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && finish) |=> req_ready);
endmodule

// File: rtl/period_index_queue.sv
module period_index_queue
  import pidxq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int NUM_PERIODS = 16,
  parameter int TMO_W       = 16,
  parameter int DROP_W      = 16,
  parameter int IDX_W       = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TMO_W-1:0]  tmo_cycles,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [1:0]        rsp_status,
  output logic [CNT_W-1:0]  avail_count,
  output logic [DROP_W-1:0] drop_count
);
  logic [IDX_W-1:0] head_idx;
  logic [CNT_W-1:0] occ;
  logic             full, drop_evt, pop;
  rsp_status_e      status_e;

  pidxq_ring #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .push_idx(push_idx),
    .pop(pop), .head_idx(head_idx), .occ(occ), .full(full), .drop_evt(drop_evt)
  );

  pidxq_avail #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_avail (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .pop(pop), .at_cap(full),
    .avail(avail_count), .drops(drop_count)
  );

  pidxq_ctrl #(.IDX_W(IDX_W), .TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tmo_cfg(tmo_cycles),
    .avail_nz(avail_count != '0), .occ_nz(occ != '0), .head_idx(head_idx),
    .req_ready(req_ready), .pop(pop), .rsp_valid(rsp_valid),
    .rsp_idx(rsp_idx), .rsp_status(status_e)
  );

  assign rsp_status = status_e;

  // R9: ready count and store occupancy agree
  p_count_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    avail_count == occ);
  // R9: bad-state code never produced
  p_no_badstate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd2));
  // R3: a drop event is visible as a replacement at the ports
  p_drop_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (avail_count == CNT_W'(DEPTH)));
endmodule

// File: tb/tb_period_index_queue.sv
module tb_period_index_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int NP = 6;
  localparam int IW = 3;
  localparam int TW = 8;
  localparam int CW = 3;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, req_valid = 0;
  logic [IW-1:0] push_idx = '0;
  logic [TW-1:0] tmo_cycles = '0;
  logic req_ready, rsp_valid;
  logic [IW-1:0] rsp_idx;
  logic [1:0] rsp_status;
  logic [CW-1:0] avail_count;
  logic [DW-1:0] drop_count;

  int checks = 0, failures = 0, cyc = 0;
  int q[$];
  int exp_drops = 0;
  int next_idx = 0;

  period_index_queue #(.DEPTH(DEPTH), .NUM_PERIODS(NP), .TMO_W(TW), .DROP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_idx(push_idx),
    .req_valid(req_valid), .req_ready(req_ready), .tmo_cycles(tmo_cycles),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_status(rsp_status),
    .avail_count(avail_count), .drop_count(drop_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int take_idx();
    int v = next_idx;
    next_idx = (next_idx + 1) % NP;
    return v;
  endfunction

  function automatic void model_push(input int v);
    if (q.size() == DEPTH) begin
      void'(q.pop_front());
      exp_drops++;
    end
    q.push_back(v);
  endfunction

  task automatic do_push();
    int v = take_idx();
    push_valid = 1; push_idx = IW'(v);
    @(negedge clk);
    push_valid = 0;
    model_push(v);
  endtask

  task automatic do_req(input int t, output int st, output int idx, output int lat);
    tmo_cycles = TW'(t); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rsp_valid && lat < 200) begin
      if (lat == 0) chk(req_ready == 0, "R6 ready low while waiting", int'(req_ready), 0);
      @(negedge clk);
      lat++;
    end
    st = int'(rsp_status); idx = int'(rsp_idx);
    chk(st != 2, "R9 no bad-state code", st, 0);
  endtask

  task automatic pop_expect(input string tag);
    int st, idx, lat, e;
    e = q.pop_front();
    do_req(0, st, idx, lat);
    chk(st == 0, {tag, " R4 status ok"}, st, 0);
    chk(idx == e, {tag, " R4 fifo order"}, idx, e);
    chk(lat == 0, {tag, " R5 same-edge answer"}, lat, 0);
  endtask

  initial begin
    int st, idx, lat, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(avail_count == 0, "R1 avail reset", int'(avail_count), 0);
    chk(drop_count == 0, "R1 drops reset", int'(drop_count), 0);
    chk(req_ready == 1, "R1 ready reset", int'(req_ready), 1);
    chk(rsp_valid == 0, "R1 rsp reset", int'(rsp_valid), 0);

    // R2 / R4 / R5: every fill level, drained in order
    for (int k = 1; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) do_push();
      chk(int'(avail_count) == k, "R2 count after pushes", int'(avail_count), k);
      for (int i = 0; i < k; i++) begin
        pop_expect("sweep");
        chk(int'(avail_count) == q.size(), "R5 count after pop", int'(avail_count), q.size());
      end
    end

    // R10: response lasts one cycle
    do_push();
    do_req(0, st, idx, lat);
    void'(q.pop_front());
    @(negedge clk);
    chk(rsp_valid == 0, "R10 single-cycle response", int'(rsp_valid), 0);

    // R3: overrun by three
    for (int i = 0; i < DEPTH + 3; i++) do_push();
    chk(int'(avail_count) == DEPTH, "R3 count held at depth", int'(avail_count), DEPTH);
    chk(int'(drop_count) == exp_drops, "R3 drop count", int'(drop_count), exp_drops);
    for (int i = 0; i < DEPTH; i++) pop_expect("overrun");

    // R7: timeout sweep on an empty queue
    for (int t = 0; t <= 6; t++) begin
      do_req(t, st, idx, lat);
      chk(st == 1, "R7 no-data status", st, 1);
      chk(lat == t, "R7 timeout latency", lat, t);
      @(negedge clk);
    end

    // R6: blocked request served by a later push
    tmo_cycles = TW'(20); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 0, "R6 waiting no response", int'(rsp_valid), 0);
    @(negedge clk);
    e = take_idx();
    push_valid = 1; push_idx = IW'(e);
    @(negedge clk);
    push_valid = 0;
    chk(rsp_valid == 0, "R6 not yet served", int'(rsp_valid), 0);
    chk(req_ready == 0, "R6 ready low", int'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_status == 0, "R6 served after push", int'(rsp_status), 0);
    chk(int'(rsp_idx) == e, "R6 served index", int'(rsp_idx), e);
    chk(avail_count == 0, "R6 count after serve", int'(avail_count), 0);
    @(negedge clk);

    // R8: simultaneous push and pop at partial and full occupancy
    for (int fill = 2; fill <= DEPTH; fill += DEPTH - 2) begin
      int dr0, v;
      for (int i = 0; i < fill; i++) do_push();
      dr0 = exp_drops;
      e = q.pop_front();
      v = take_idx();
      q.push_back(v);
      push_valid = 1; push_idx = IW'(v); req_valid = 1; tmo_cycles = '0;
      @(negedge clk);
      push_valid = 0; req_valid = 0;
      chk(rsp_valid == 1 && int'(rsp_idx) == e, "R8 pop returns old head", int'(rsp_idx), e);
      chk(int'(avail_count) == fill, "R8 count unchanged", int'(avail_count), fill);
      chk(int'(drop_count) == dr0, "R8 no drop", int'(drop_count), dr0);
      while (q.size() > 0) pop_expect("R8 drain");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule